// File: doc/BRIEF.md
# Snooping Write-Back Cache Controller

This block sequences an external direct-mapped, unified, write-back cache. The cache is indexed with virtual address bits and tagged with physical page numbers. The processor presents a request with a virtual line index, a 64-bit beat number inside the 32-byte line, and the physical page number and cacheable flag from the translation buffer. The controller compares tags and drives the enables and address of the external data RAM. On a miss it writes back a dirty victim, then fetches the new line over a single request/acknowledge memory handshake. The victim's physical line address comes from the stored tag, so no new translation is needed.

A second tag copy is kept for the bus side. It is read in the same cycle as the processor copy, and both copies are written together on a refill. A bus controller presents snoop commands of three kinds: a remote write, a remote read, and a request that this cache supply a block. A remote write that hits invalidates the line. A block request that hits a dirty line raises a supply indication. Any memory transfer that ends with an error flag is repeated.

The processor request port is valid/ready. `cpu_req_ready` is high only when the controller is idle, and a request is taken on a clock edge where valid and ready are both high. The controller holds `mem_req` and its address, beat, direction and lane fields until `mem_ack`. The snoop port has no back-pressure.

Top module: `scc_ctrl`

## Requirements
- R1: After reset, `cpu_req_ready` is 1, `cpu_stall` is 0, `mem_req` is 0, and every line is invalid, so the first cached access misses.
- R2: A cacheable request whose index holds a valid line with a matching tag completes in the first cycle after acceptance. In that cycle `cpu_done` is 1, `cpu_stall` is 0, no memory request is made, `dram_en` is 1, `dram_we` equals the request's write flag, and `dram_addr` is {index, beat}.
- R3: A cacheable miss to a clean or invalid line fetches four beats in order 0,1,2,3, each with `mem_write`=0, `mem_lane`=2'b11 and `mem_addr`={requested page, index}. `mem_req` is held with stable fields until acknowledged.
- R4: A miss to a valid dirty line first writes back four beats 0..3 with `mem_write`=1 to {stored tag, index}, and only then fetches the new line.
- R5: A write that hits or refills leaves the line dirty. A read refill leaves it clean.
- R6: A memory acknowledge that comes with `mem_err` high is not taken as completion. A block transfer whose last beat is flagged restarts at beat 0, and a single bypass beat is repeated.
- R7: A request with the cacheable flag clear makes exactly one memory transfer at {page, index} with the request's beat and direction, and it changes neither the tags nor the line state.
- R8: `mem_lane` bit 0 selects the data bus and bit 1 selects the address bus. A bypass double word uses 2'b11. A single word uses 2'b10 when its word select (address bit 2) is 1 and 2'b01 when it is 0. Block beats use 2'b11.
- R9: A snoop with `snp_cmd`=2'd1 (remote write) that matches a valid line makes `snp_hit` 1 in the next cycle and invalidates the line, so the next processor access to it misses with no write-back.
- R10: A snoop with `snp_cmd`=2'd2 (remote read) reports a hit the same way and changes no line state.
- R11: A snoop with `snp_cmd`=2'd3 (block request) sets `snp_supply` in the next cycle only if it hits a dirty line. `snp_hit` follows the match for every command.
- R12: While a request is being served (`cpu_stall` high, or in the completion cycle), `cpu_req_ready` is 0. `cpu_stall` rises in the cycle a miss or bypass is detected and stays high through the `cpu_done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_dw | input | 1 | Double-word access |
| cpu_req_word | input | 1 | Word select (address bit 2) for single words |
| cpu_req_cacheable | input | 1 | Page cacheable flag from translation |
| cpu_req_index | input | IDX_W | Virtual line index |
| cpu_req_beat | input | BEAT_W | 64-bit beat inside the line |
| cpu_req_ppn | input | TAG_W | Physical page number |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_stall | output | 1 | Miss or bypass in progress |
| dram_en | output | 1 | Data RAM enable |
| dram_we | output | 1 | Data RAM write enable |
| dram_addr | output | IDX_W+BEAT_W | Data RAM address {index, beat} |
| mem_req | output | 1 | Memory transfer request |
| mem_write | output | 1 | 1 = write to memory |
| mem_addr | output | TAG_W+IDX_W | Physical line address {page, index} |
| mem_beat | output | BEAT_W | Beat of the transfer |
| mem_lane | output | 2 | Bus lanes used (bit1 address bus, bit0 data bus) |
| mem_ack | input | 1 | Transfer acknowledge |
| mem_err | input | 1 | Error on the acknowledged transfer |
| snp_valid | input | 1 | Snoop command valid |
| snp_cmd | input | 2 | 1 remote write, 2 remote read, 3 block request |
| snp_index | input | IDX_W | Snooped line index |
| snp_ppn | input | TAG_W | Snooped physical page |
| snp_hit | output | 1 | Previous-cycle snoop matched a valid line |
| snp_supply | output | 1 | Previous-cycle block request hit a dirty line |

## Verification
On every cycle, the bound checker enforces the bus rules: the memory request stays stable until it is acknowledged, a flagged acknowledge is always followed by a further request, and lanes are never empty. It also checks that hits never touch the bus, that no request is accepted while one is being served, and that supply implies hit. Only the bench scenarios can show the order of write-back and fetch, the addresses taken from the stored tag, the restart at beat 0, that bypass and remote reads leave the tags untouched, and that a remote write turns a later hit into a miss.

// File: rtl/scc_pkg.sv
package scc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_WBACK, ST_FILL, ST_BYPASS, ST_FINISH
  } ctrl_st_t;

  localparam logic [1:0] SNP_NONE  = 2'd0;
  localparam logic [1:0] SNP_WRITE = 2'd1;
  localparam logic [1:0] SNP_READ  = 2'd2;
  localparam logic [1:0] SNP_BLOCK = 2'd3;

  localparam logic [1:0] LANE_BOTH = 2'b11;
  localparam logic [1:0] LANE_ADDR = 2'b10;
  localparam logic [1:0] LANE_DATA = 2'b01;
endpackage

// File: rtl/scc_tag_copy.sv
module scc_tag_copy #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag
);
  localparam int LINES = 1 << IDX_W;
  logic [TAG_W-1:0] tags [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) tags[wr_idx] <= wr_tag;
  end

  assign rd_tag = tags[rd_idx];
endmodule

// File: rtl/scc_line_state.sv
module scc_line_state #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic             fill_dirty,
  input  logic             mark_dirty,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic             inval_en,
  input  logic [IDX_W-1:0] snp_idx,
  output logic             cpu_valid,
  output logic             cpu_dirty,
  output logic             snp_valid_bit,
  output logic             snp_dirty_bit
);
  localparam int LINES = 1 << IDX_W;
  logic [LINES-1:0] valid_q, dirty_q;

  // Priority at one edge: refill beats invalidate beats store-dirty.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (mark_dirty) dirty_q[cpu_idx] <= 1'b1;
      if (inval_en)   valid_q[snp_idx] <= 1'b0;
      if (fill_en) begin
        valid_q[cpu_idx] <= 1'b1;
        dirty_q[cpu_idx] <= fill_dirty;
      end
    end
  end

  assign cpu_valid     = valid_q[cpu_idx];
  assign cpu_dirty     = dirty_q[cpu_idx];
  assign snp_valid_bit = valid_q[snp_idx];
  assign snp_dirty_bit = dirty_q[snp_idx];
endmodule

// File: rtl/scc_ctrl.sv
module scc_ctrl
  import scc_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 20,
  parameter int BEAT_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req_valid,
  output logic                    cpu_req_ready,
  input  logic                    cpu_req_write,
  input  logic                    cpu_req_dw,
  input  logic                    cpu_req_word,
  input  logic                    cpu_req_cacheable,
  input  logic [IDX_W-1:0]        cpu_req_index,
  input  logic [BEAT_W-1:0]       cpu_req_beat,
  input  logic [TAG_W-1:0]        cpu_req_ppn,
  output logic                    cpu_done,
  output logic                    cpu_stall,
  output logic                    dram_en,
  output logic                    dram_we,
  output logic [IDX_W+BEAT_W-1:0] dram_addr,
  output logic                    mem_req,
  output logic                    mem_write,
  output logic [TAG_W+IDX_W-1:0]  mem_addr,
  output logic [BEAT_W-1:0]       mem_beat,
  output logic [1:0]              mem_lane,
  input  logic                    mem_ack,
  input  logic                    mem_err,
  input  logic                    snp_valid,
  input  logic [1:0]              snp_cmd,
  input  logic [IDX_W-1:0]        snp_index,
  input  logic [TAG_W-1:0]        snp_ppn,
  output logic                    snp_hit,
  output logic                    snp_supply
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};
  localparam int NCOPY = 2;

  ctrl_st_t st_q, st_d;
  logic [IDX_W-1:0]  r_idx;
  logic [TAG_W-1:0]  r_ppn;
  logic [BEAT_W-1:0] r_beat, cnt_q;
  logic r_write, r_dw, r_word, r_ca;

  logic [IDX_W-1:0] tag_ra [NCOPY];
  logic [TAG_W-1:0] tag_rd [NCOPY];
  logic fill_en, mark_dirty, inval_en;
  logic l_valid, l_dirty, s_valid, s_dirty;
  logic cpu_hit, snp_match, accept;

  assign tag_ra[0] = r_idx;
  assign tag_ra[1] = snp_index;

  // Processor and snoop tag copies: separate read ports, common write.
  for (genvar g = 0; g < NCOPY; g++) begin : g_tag
    scc_tag_copy #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_copy (
      .clk(clk), .wr_en(fill_en), .wr_idx(r_idx), .wr_tag(r_ppn),
      .rd_idx(tag_ra[g]), .rd_tag(tag_rd[g])
    );
  end

  scc_line_state #(.IDX_W(IDX_W)) u_state (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_dirty(r_write),
    .mark_dirty(mark_dirty), .cpu_idx(r_idx), .inval_en(inval_en),
    .snp_idx(snp_index), .cpu_valid(l_valid), .cpu_dirty(l_dirty),
    .snp_valid_bit(s_valid), .snp_dirty_bit(s_dirty)
  );

  assign cpu_hit   = l_valid && (tag_rd[0] == r_ppn);
  assign snp_match = snp_valid && (snp_cmd != SNP_NONE) && s_valid &&
                     (tag_rd[1] == snp_ppn);
  assign inval_en  = snp_match && (snp_cmd == SNP_WRITE);
  assign accept    = cpu_req_valid && cpu_req_ready;

  always_comb begin
    st_d          = st_q;
    cpu_req_ready = 1'b0;
    cpu_done      = 1'b0;
    cpu_stall     = 1'b0;
    dram_en       = 1'b0;
    dram_we       = 1'b0;
    dram_addr     = {r_idx, r_beat};
    mem_req       = 1'b0;
    mem_write     = 1'b0;
    mem_addr      = {r_ppn, r_idx};
    mem_beat      = cnt_q;
    mem_lane      = LANE_BOTH;
    fill_en       = 1'b0;
    mark_dirty    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cpu_req_ready = 1'b1;
        if (cpu_req_valid) st_d = ST_LOOK;
      end
      ST_LOOK: begin
        if (!r_ca) begin
          cpu_stall = 1'b1;
          st_d      = ST_BYPASS;
        end else if (cpu_hit) begin
          cpu_done   = 1'b1;
          dram_en    = 1'b1;
          dram_we    = r_write;
          mark_dirty = r_write;
          st_d       = ST_IDLE;
        end else begin
          cpu_stall = 1'b1;
          st_d      = (l_valid && l_dirty) ? ST_WBACK : ST_FILL;
        end
      end
      ST_WBACK: begin
        cpu_stall = 1'b1;
        mem_req   = 1'b1;
        mem_write = 1'b1;
        mem_addr  = {tag_rd[0], r_idx};
        dram_en   = 1'b1;
        dram_addr = {r_idx, cnt_q};
        if (mem_ack && !mem_err && cnt_q == LAST_BEAT) st_d = ST_FILL;
      end
      ST_FILL: begin
        cpu_stall = 1'b1;
        mem_req   = 1'b1;
        dram_en   = mem_ack;
        dram_we   = mem_ack;
        dram_addr = {r_idx, cnt_q};
        if (mem_ack && !mem_err && cnt_q == LAST_BEAT) st_d = ST_FINISH;
      end
      ST_FINISH: begin
        cpu_stall = 1'b1;
        cpu_done  = 1'b1;
        dram_en   = 1'b1;
        dram_we   = r_write;
        fill_en   = 1'b1;
        st_d      = ST_IDLE;
      end
      ST_BYPASS: begin
        cpu_stall = 1'b1;
        mem_req   = 1'b1;
        mem_write = r_write;
        mem_beat  = r_beat;
        mem_lane  = r_dw ? LANE_BOTH : (r_word ? LANE_ADDR : LANE_DATA);
        if (mem_ack && !mem_err) begin
          cpu_done = 1'b1;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      r_idx      <= '0;
      r_ppn      <= '0;
      r_beat     <= '0;
      r_write    <= 1'b0;
      r_dw       <= 1'b0;
      r_word     <= 1'b0;
      r_ca       <= 1'b0;
      snp_hit    <= 1'b0;
      snp_supply <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q) cnt_q <= '0;
      else if (mem_ack && (st_q == ST_WBACK || st_q == ST_FILL))
        cnt_q <= cnt_q + 1'b1;  // wraps to 0 when a flagged block restarts
      if (accept) begin
        r_idx   <= cpu_req_index;
        r_ppn   <= cpu_req_ppn;
        r_beat  <= cpu_req_beat;
        r_write <= cpu_req_write;
        r_dw    <= cpu_req_dw;
        r_word  <= cpu_req_word;
        r_ca    <= cpu_req_cacheable;
      end
      snp_hit    <= snp_match;
      snp_supply <= snp_match && s_dirty && (snp_cmd == SNP_BLOCK);
    end
  end
endmodule

// File: rtl/scc_checker.sv
module scc_checker #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 20,
  parameter int BEAT_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cpu_req_ready,
  input logic                   cpu_done,
  input logic                   cpu_stall,
  input logic                   mem_req,
  input logic                   mem_write,
  input logic [TAG_W+IDX_W-1:0] mem_addr,
  input logic [BEAT_W-1:0]      mem_beat,
  input logic [1:0]             mem_lane,
  input logic                   mem_ack,
  input logic                   mem_err,
  input logic                   snp_hit,
  input logic                   snp_supply
);
  // R12
  busy_blocks_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stall || cpu_done) |-> !cpu_req_ready);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_beat) && $stable(mem_write)));

  // R2
  hit_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && !cpu_stall) |-> !mem_req);

  // R6
  err_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> mem_req);

  // R8
  lane_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_lane != 2'b00));

  // R11
  supply_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> snp_hit);
endmodule

bind scc_ctrl scc_checker #(.IDX_W(IDX_W), .TAG_W(TAG_W), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req_ready(cpu_req_ready), .cpu_done(cpu_done),
  .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_write(mem_write),
  .mem_addr(mem_addr), .mem_beat(mem_beat), .mem_lane(mem_lane),
  .mem_ack(mem_ack), .mem_err(mem_err), .snp_hit(snp_hit), .snp_supply(snp_supply)
);

// File: tb/sim_scc_ctrl.sv
module sim_scc_ctrl;
  localparam int IDX_W = 6, TAG_W = 20, BEAT_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req_valid = 0, cpu_req_ready, cpu_req_write = 0, cpu_req_dw = 0;
  logic cpu_req_word = 0, cpu_req_cacheable = 0;
  logic [IDX_W-1:0] cpu_req_index = '0;
  logic [BEAT_W-1:0] cpu_req_beat = '0;
  logic [TAG_W-1:0] cpu_req_ppn = '0;
  logic cpu_done, cpu_stall, dram_en, dram_we;
  logic [IDX_W+BEAT_W-1:0] dram_addr;
  logic mem_req, mem_write;
  logic [TAG_W+IDX_W-1:0] mem_addr;
  logic [BEAT_W-1:0] mem_beat;
  logic [1:0] mem_lane;
  logic mem_ack = 0, mem_err = 0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = '0;
  logic [IDX_W-1:0] snp_index = '0;
  logic [TAG_W-1:0] snp_ppn = '0;
  logic snp_hit, snp_supply;

  int total = 0, bad = 0, cyc = 0;

  // memory responder log
  logic [TAG_W+IDX_W-1:0] lg_addr [16];
  logic lg_we [16];
  logic [BEAT_W-1:0] lg_beat [16];
  logic [1:0] lg_lane [16];
  int n_log = 0;
  bit err_arm = 0;
  logic [BEAT_W-1:0] err_beat = '0;

  // result of the last request
  int lat;
  bit stall_ok, ready_ok, d_stall, d_en, d_we;
  logic [IDX_W+BEAT_W-1:0] d_addr;

  always #5 clk = ~clk;

  scc_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .BEAT_W(BEAT_W)) u0 (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, act=%0d exp<=20000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 0;
      mem_err = 0;
    end else if (mem_req) begin
      mem_ack = 1;
      mem_err = err_arm && (mem_beat == err_beat);
      if (mem_err) err_arm = 0;
      if (n_log < 16) begin
        lg_addr[n_log] = mem_addr; lg_we[n_log] = mem_write;
        lg_beat[n_log] = mem_beat; lg_lane[n_log] = mem_lane;
      end
      n_log++;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic cpu_op(bit wr, bit dw, bit word, bit ca, int idx, int beat, int ppn);
    tick();
    n_log = 0;
    cpu_req_valid = 1; cpu_req_write = wr; cpu_req_dw = dw; cpu_req_word = word;
    cpu_req_cacheable = ca; cpu_req_index = idx[IDX_W-1:0];
    cpu_req_beat = beat[BEAT_W-1:0]; cpu_req_ppn = ppn[TAG_W-1:0];
    tick();
    cpu_req_valid = 0;
    lat = 1; stall_ok = 1; ready_ok = 1;
    for (int i = 0; i < 200; i++) begin
      if (cpu_req_ready) ready_ok = 0;
      if (cpu_done) break;
      if (!cpu_stall) stall_ok = 0;
      tick();
      lat++;
    end
    d_stall = cpu_stall; d_en = dram_en; d_we = dram_we; d_addr = dram_addr;
  endtask

  task automatic chk_block(int first, int ppn, int idx, bit we, string req);
    logic [TAG_W+IDX_W-1:0] ea;
    ea = {ppn[TAG_W-1:0], idx[IDX_W-1:0]};
    for (int b = 0; b < 4; b++) begin
      chk(lg_addr[first+b] == ea && lg_we[first+b] == we &&
          lg_beat[first+b] == b[BEAT_W-1:0] && lg_lane[first+b] == 2'b11,
          req, "block beat addr/we/beat", lg_addr[first+b], ea);
    end
  endtask

  task automatic chk_hit(bit wr, int idx, int beat, string req);
    chk(lat == 1 && !d_stall && n_log == 0, req, "hit latency/no bus", lat, 1);
    chk(d_en && d_we == wr && d_addr == {idx[IDX_W-1:0], beat[BEAT_W-1:0]},
        req, "hit dram addr", d_addr, {idx[IDX_W-1:0], beat[BEAT_W-1:0]});
  endtask

  task automatic snoop(int cmd, int idx, int ppn, bit eh, bit es, string req);
    tick();
    snp_valid = 1; snp_cmd = cmd[1:0]; snp_index = idx[IDX_W-1:0]; snp_ppn = ppn[TAG_W-1:0];
    tick();
    snp_valid = 0; snp_cmd = 2'd0;
    chk(snp_hit == eh, req, "snp_hit", snp_hit, eh);
    chk(snp_supply == es, req, "snp_supply", snp_supply, es);
  endtask

  task automatic t_reset();
    chk(cpu_req_ready == 1 && cpu_stall == 0 && mem_req == 0, "R1", "reset outputs",
        {cpu_req_ready, cpu_stall, mem_req}, 3'b100);
  endtask

  task automatic t_clean_miss();
    cpu_op(0, 1, 0, 1, 5, 2, 'hA1);
    chk(n_log == 4, "R1", "first access misses, beats", n_log, 4);
    chk_block(0, 'hA1, 5, 0, "R3");
    chk(stall_ok && d_stall, "R12", "stall held to done", {stall_ok, d_stall}, 2'b11);
    chk(ready_ok, "R12", "ready low while busy", ready_ok, 1);
    chk(d_en && !d_we && d_addr == {6'd5, 2'd2}, "R3", "refill word to cpu", d_addr, {6'd5, 2'd2});
  endtask

  task automatic t_hits();
    cpu_op(0, 1, 0, 1, 5, 1, 'hA1);
    chk_hit(0, 5, 1, "R2");
    cpu_op(1, 1, 0, 1, 5, 3, 'hA1);
    chk_hit(1, 5, 3, "R2");
  endtask

  task automatic t_dirty_evict();
    cpu_op(0, 1, 0, 1, 5, 0, 'hB2);
    chk(n_log == 8, "R4", "writeback+fill beats", n_log, 8);
    chk_block(0, 'hA1, 5, 1, "R4");
    chk_block(4, 'hB2, 5, 0, "R5");
  endtask

  task automatic t_retry();
    err_arm = 1; err_beat = 2'd3;
    cpu_op(0, 1, 0, 1, 9, 0, 'hC3);
    chk(n_log == 8, "R6", "flagged block repeated", n_log, 8);
    chk_block(0, 'hC3, 9, 0, "R6");
    chk_block(4, 'hC3, 9, 0, "R6");
    cpu_op(0, 1, 0, 1, 9, 0, 'hC3);
    chk_hit(0, 9, 0, "R6");
  endtask

  task automatic t_bypass();
    cpu_op(0, 0, 1, 0, 9, 1, 'hD4);
    chk(n_log == 1 && lg_addr[0] == {20'hD4, 6'd9} && lg_beat[0] == 1 && !lg_we[0],
        "R7", "single bypass read", lg_addr[0], {20'hD4, 6'd9});
    chk(lg_lane[0] == 2'b10, "R8", "word1 uses address bus", lg_lane[0], 2'b10);
    chk(stall_ok && d_stall, "R12", "bypass stall", {stall_ok, d_stall}, 2'b11);
    cpu_op(0, 1, 0, 1, 9, 2, 'hC3);
    chk_hit(0, 9, 2, "R7");
    cpu_op(1, 0, 0, 0, 9, 3, 'hD4);
    chk(n_log == 1 && lg_we[0] && lg_lane[0] == 2'b01, "R8", "word0 uses data bus",
        lg_lane[0], 2'b01);
    err_arm = 1; err_beat = 2'd2;
    cpu_op(0, 1, 0, 0, 9, 2, 'hD4);
    chk(n_log == 2 && lg_beat[0] == 2 && lg_beat[1] == 2, "R6", "bypass beat repeated",
        n_log, 2);
    chk(lg_lane[1] == 2'b11, "R8", "double word lanes", lg_lane[1], 2'b11);
  endtask

  task automatic t_snoop();
    snoop(2, 5, 'hB2, 1, 0, "R10");
    cpu_op(0, 1, 0, 1, 5, 0, 'hB2);
    chk_hit(0, 5, 0, "R10");
    snoop(3, 5, 'hB2, 1, 0, "R11");
    cpu_op(1, 1, 0, 1, 5, 0, 'hB2);
    chk_hit(1, 5, 0, "R5");
    snoop(3, 5, 'hB2, 1, 1, "R11");
    snoop(3, 5, 'hA1, 0, 0, "R11");
    snoop(1, 5, 'hB2, 1, 0, "R9");
    cpu_op(0, 1, 0, 1, 5, 0, 'hB2);
    chk(n_log == 4, "R9", "invalidated line refetched, no writeback", n_log, 4);
    chk_block(0, 'hB2, 5, 0, "R9");
    snoop(2, 5, 'hB2, 1, 0, "R10");
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_clean_miss();
    t_hits();
    t_dirty_evict();
    t_retry();
    t_bypass();
    t_snoop();
    repeat (3) tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule